// File: doc/BRIEF.md
# Pilot PWM Timer with Sample Trigger

This block is an up-counting timer that produces the pulse-width-modulated pilot signal for a vehicle charging station. It also produces a companion square wave that marks each period boundary, so that a converter can take its samples while the pilot is high. A free-running counter climbs from zero to a programmable limit and then returns to zero. A duty channel drives the pilot: it goes high when a period starts and low once the count reaches the duty value. A period channel inverts its output at every rollover. That output therefore runs at half the pilot rate. A converter that flips the edge it waits for after every trigger gets one trigger per pilot period, and that trigger falls at the pilot's rising edge.

The period and duty values can be rewritten while the timer runs. A new duty value waits in a shadow register until the next rollover, so a write in the middle of a period never cuts a pulse short or adds an extra one. A one-cycle flag reports each rollover. A clear input puts the counter back to zero so that counting starts cleanly. At a 1 kHz pilot the duty can be set anywhere from 5 % to 96 %.

Top module: `pilot_pwm_timer`

## Requirements
- R1: With run_i high, the counter steps 0, 1, …, P and then returns to 0, where P is period_i. A period of N clocks is programmed as P = N-1. If P is lowered below the present count, the next counted step returns the counter to 0.
- R2: wrap_o is high for exactly one cycle: the cycle in which the counter holds 0 after a rollover. A clear never raises it.
- R3: With duty_mode_i = 7 (reset/set), pwm_o is high while the count is 0 through D-1 and low for the rest of the period, where D is the active duty value. This makes the high time D clocks out of P+1.
- R4: A new duty_i becomes active only at a rollover or a clear. A change in the middle of a period has no effect on the period in progress.
- R5: An active duty of 0 keeps pwm_o low through every period. An active duty greater than P keeps it high.
- R6: With per_mode_i = 4 (toggle), cmp0_tgl_o inverts at every rollover and at no other time. Its period is therefore 2·(P+1) clocks.
- R7: clear_i high on a clock edge does four things: it sets the counter to 0, loads duty_i as the active duty, and in reset/set mode sets pwm_o to (duty_i ≠ 0). It also leaves cmp0_tgl_o unchanged. A clear overrides a rollover that falls on the same edge.
- R8: With run_i low and clear_i low, the counter and all three outputs hold their values.
- R9: Any mode code other than 7 on duty_mode_i freezes pwm_o. Any mode code other than 4 on per_mode_i freezes cmp0_tgl_o.
- R10: While rst_ni is low, pwm_o, cmp0_tgl_o and wrap_o are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Up-count enable |
| clear_i | input | 1 | Synchronous counter clear and duty reload |
| period_i | input | CNT_W | Period limit, written as clocks minus one |
| duty_i | input | CNT_W | Duty compare value, held in the shadow register until a rollover |
| duty_mode_i | input | 3 | Output mode of the duty channel (7 = reset/set) |
| per_mode_i | input | 3 | Output mode of the period channel (4 = toggle) |
| pwm_o | output | 1 | Pilot PWM output |
| cmp0_tgl_o | output | 1 | Half-rate toggle used as the sample trigger |
| wrap_o | output | 1 | One-cycle rollover flag |

## Verification
Three events can land on the same clock edge: a rollover, a shadow load of a new duty value, and a clear. The bench provokes each pairing on purpose. It writes duty_i on the exact cycle the counter sits at P, so the load and the rollover meet. It raises clear_i at that same count, so the clear meets the rollover. It also lowers P below a running count. In every case a behavioural reference model gives the expected values of pwm_o, cmp0_tgl_o and wrap_o, and the bench compares them on every clock. Separate directed measurements count the high clocks in one full period at 5 % and 96 % duty, and at duty values of 0 and above P.

// File: rtl/pilot_pwm_pkg.sv
package pilot_pwm_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] outmode_t;
  localparam outmode_t OM_TOGGLE = 3'd4;
  localparam outmode_t OM_RSTSET = 3'd7;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_o,
  output logic             wrap_ev_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_top;
  logic             wrap_q, wrap_d;

  // next-state
  always_comb begin
    at_top    = (cnt_q >= period_i);
    step_o    = run_i & ~clear_i;
    wrap_ev_o = step_o & at_top;
    cnt_nxt_o = at_top ? '0 : cnt_q + 1'b1;
    cnt_en    = clear_i | step_o;
    cnt_d     = clear_i ? '0 : cnt_nxt_o;
    wrap_d    = wrap_ev_o;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign wrap_o = wrap_q;

  // R1: a counted step below the limit advances by one
  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1: reaching or passing the limit returns to zero
  p_wrap_to_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q >= period_i) |=> (cnt_q == '0));
  // R2: the flag only appears while the count is zero
  p_flag_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> (cnt_q == '0));
  // R7: clear zeroes the count and suppresses the flag
  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && !wrap_q));
  // R8: idle holds the count
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_duty_channel.sv
module pwm_duty_channel
  import pilot_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  outmode_t         mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             wrap_ev_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic             pwm_q, pwm_d;
  logic             load;
  logic             is_rs;

  // next-state
  always_comb begin
    load     = clear_i | wrap_ev_i;
    is_rs    = (mode_i == OM_RSTSET);
    shadow_d = load ? duty_i : shadow_q;
    pwm_d    = pwm_q;
    if (is_rs) begin
      if (load)
        pwm_d = (duty_i != '0);
      else if (step_i && cnt_nxt_i == shadow_q)
        pwm_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (load) shadow_q <= shadow_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R4: the active duty changes only at a rollover or clear
  p_shadow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_i || wrap_ev_i) |=> $stable(shadow_q));
  // R5: a zero duty loaded in reset/set mode leaves the output low
  p_zero_duty_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rs && (clear_i || wrap_ev_i) && duty_i == '0) |=> !pwm_q);
  // R9: foreign mode codes freeze the output
  p_mode_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rs |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_period_channel.sv
module pwm_period_channel
  import pilot_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  outmode_t mode_i,
  input  logic     wrap_ev_i,
  output logic     tgl_o
);
  logic tgl_q, tgl_d, tgl_en;

  always_comb begin
    tgl_en = wrap_ev_i & (mode_i == OM_TOGGLE);
    tgl_d  = ~tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

  // R6: a rollover in toggle mode inverts the output
  p_toggle_on_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_ev_i && mode_i == OM_TOGGLE) |=> (tgl_q != $past(tgl_q)));
  // R6: no rollover, no change
  p_toggle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_ev_i |=> $stable(tgl_q));
endmodule

// File: rtl/pilot_pwm_timer.sv
module pilot_pwm_timer
  import pilot_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [2:0]       duty_mode_i,
  input  logic [2:0]       per_mode_i,
  output logic             pwm_o,
  output logic             cmp0_tgl_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic             wrap_ev;

  pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .clear_i   (clear_i),
    .period_i  (period_i),
    .cnt_nxt_o (cnt_nxt),
    .step_o    (step),
    .wrap_ev_o (wrap_ev),
    .wrap_o    (wrap_o)
  );

  pwm_duty_channel #(.CNT_W(CNT_W)) u_duty (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (outmode_t'(duty_mode_i)),
    .duty_i    (duty_i),
    .clear_i   (clear_i),
    .step_i    (step),
    .wrap_ev_i (wrap_ev),
    .cnt_nxt_i (cnt_nxt),
    .pwm_o     (pwm_o)
  );

  pwm_period_channel u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (outmode_t'(per_mode_i)),
    .wrap_ev_i (wrap_ev),
    .tgl_o     (cmp0_tgl_o)
  );

  // R10: outputs are quiet during reset
  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r10: assert (!pwm_o && !cmp0_tgl_o && !wrap_o);
    end
  end

  // R7: clear never moves the trigger output
  p_clear_keeps_tgl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> $stable(cmp0_tgl_o));
endmodule

// File: tb/test_pilot_pwm_timer.sv
module test_pilot_pwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic clear = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] duty = '0;
  logic [2:0] dmode = 3'd7;
  logic [2:0] pmode = 3'd4;
  logic pwm, tgl, wrap;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  bit checking = 1'b0;
  string tag = "R10";

  // reference model state
  int unsigned m_cnt, m_sh;
  bit m_pwm, m_tgl, m_wrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  pilot_pwm_timer #(.CNT_W(CNT_W)) i_pilot_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clear_i(clear),
    .period_i(period), .duty_i(duty), .duty_mode_i(dmode), .per_mode_i(pmode),
    .pwm_o(pwm), .cmp0_tgl_o(tgl), .wrap_o(wrap)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = 0; m_pwm = 0; m_tgl = 0; m_wrap = 0;
    end else begin
      m_wrap = 0;
      if (clear) begin
        m_cnt = 0; m_sh = duty;
        if (dmode == 3'd7) m_pwm = (duty != 0);
      end else if (run) begin
        if (m_cnt >= period) begin
          m_cnt = 0; m_wrap = 1; m_sh = duty;
          if (dmode == 3'd7) m_pwm = (m_sh != 0);
          if (pmode == 3'd4) m_tgl = !m_tgl;
        end else begin
          m_cnt = m_cnt + 1;
          if (dmode == 3'd7 && m_cnt == m_sh) m_pwm = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(pwm == m_pwm, tag, "pwm_o", pwm, m_pwm);
      check(tgl == m_tgl, tag, "cmp0_tgl_o", tgl, m_tgl);
      check(wrap == m_wrap, tag, "wrap_o", wrap, m_wrap);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_count(input int unsigned v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic measure_high(output int h);
    do @(negedge clk); while (!wrap);
    h = 0;
    for (int i = 0; i <= int'(period); i++) begin
      if (pwm) h++;
      @(negedge clk);
    end
  endtask

  int hi;

  initial begin
    // R10: reset state
    step(3);
    check(pwm == 0 && tgl == 0 && wrap == 0, "R10", "outputs in reset",
          {pwm, tgl, wrap}, 0);
    rst_n = 1'b1;
    checking = 1'b1;
    step(2);

    // R1 R2 R3 R6: basic run, P=9, D=3
    tag = "R1/R2/R3/R6";
    period = 16'd9; duty = 16'd3;
    clear = 1'b1; step(1); clear = 1'b0;
    run = 1'b1;
    step(60);
    measure_high(hi);
    check(hi == 3, "R3", "high clocks D=3 P=9", hi, 3);

    // R4: mid-period write, and a write on the rollover cycle
    tag = "R4";
    wait_count(2); duty = 16'd7;
    step(1);
    wait_count(9); duty = 16'd5;
    step(25);
    measure_high(hi);
    check(hi == 5, "R4", "high clocks after shadow load", hi, 5);

    // R3: 5 % and 96 % at P=99
    tag = "R3";
    period = 16'd99; duty = 16'd5;
    step(210);
    measure_high(hi);
    check(hi == 5, "R3", "high clocks 5%", hi, 5);
    duty = 16'd96;
    step(210);
    measure_high(hi);
    check(hi == 96, "R3", "high clocks 96%", hi, 96);

    // R5: duty zero and duty above the limit
    tag = "R5";
    period = 16'd9; duty = 16'd0;
    step(40);
    measure_high(hi);
    check(hi == 0, "R5", "high clocks duty 0", hi, 0);
    duty = 16'd12;
    step(40);
    measure_high(hi);
    check(hi == 10, "R5", "high clocks duty>P", hi, 10);

    // R7: clear on the rollover cycle
    tag = "R7";
    duty = 16'd4;
    wait_count(9); clear = 1'b1; step(1); clear = 1'b0;
    check(wrap == 0, "R7", "no flag on clear", wrap, 0);
    step(15);
    wait_count(5); duty = 16'd0; clear = 1'b1; step(1); clear = 1'b0;
    check(pwm == 0, "R7", "pwm after clear with duty 0", pwm, 0);
    duty = 16'd3;
    step(20);

    // R1: period lowered below the running count
    tag = "R1";
    period = 16'd20;
    step(25);
    wait_count(15); period = 16'd9;
    step(1);
    check(wrap == 1, "R1", "wrap after limit lowered", wrap, 1);
    step(30);

    // R8: idle holds
    tag = "R8";
    run = 1'b0;
    step(20);
    run = 1'b1;
    step(15);

    // R9: foreign mode codes freeze outputs
    tag = "R9";
    dmode = 3'd0; pmode = 3'd1;
    step(35);
    dmode = 3'd7; pmode = 3'd4;
    step(30);

    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule